// File: doc/BRIEF.md
# Quad Serial Flash Erase Command Decoder

This block sits on the device side of a quad-wide serial flash model. While the chip-select input is low, it collects 4-bit words that arrive on a strobe. It packs each pair of words into a byte, high word first. It recognises four commands: set write permission, erase one block, erase the whole device, and read status. Erases run on the system clock: the command is checked when chip-select returns high, and only then does the erase start.

An erase goes ahead only if write permission was granted earlier and the target is not write-protected. Write protection is given as one bit per 64 KB region. When an erase is accepted, the block raises a one-cycle start pulse together with the base address and the byte size of the range to be set to all ones. A memory-array stub consumes these. The block then holds busy for a programmable number of clocks.

The size of a block erase depends on where the address falls. The two 32 KB ends of the device are split into 8 KB blocks. The 32 KB units next to each end are 32 KB blocks. Everything else is erased in 64 KB blocks.

Top module: `qflash_erase_dec`

## Requirements
- R1: After reset, busy, wel, er_start and dout_en are all 0.
- R2: A byte is two strobed words, high word first. Command 06h (exactly 2 words) sets wel when chip-select rises, provided busy is low.
- R3: Command D8h followed by three address bytes (8 words in total), with wel set and the target unprotected, pulses er_start for exactly one clock. The pulse comes in the cycle after the edge at which chip-select is first sampled high. er_base and er_size are valid in that same cycle.
- R4: Let seg be address bits [ADDR_W-1:15]. If seg is 0 or all ones, the block size is 8 KB. If seg is 1 or all ones minus 1, the size is 32 KB. Otherwise the size is 64 KB. er_base is the address with the bits below the size cleared.
- R5: Command C7h (exactly 2 words) with wel set and no protection bit set erases base 0 with size 2^ADDR_W.
- R6: An erase command that arrives while wel is 0 produces no er_start.
- R7: A block erase is ignored when prot[address bits 20:16] is set. A chip erase is ignored when any prot bit is set. In both cases wel is cleared.
- R8: wel is cleared in the same cycle as an accepted erase starts.
- R9: A command with the wrong word count is discarded when chip-select rises: no erase starts and wel is unchanged. This covers a command cut short and one with extra words.
- R10: busy rises together with er_start and stays high for busy_len clocks. A busy_len of 0 counts as 1.
- R11: While busy is high, commands 06h, D8h and C7h have no effect.
- R12: Command 05h works at any time and turns on dout_en. dout then shows the high word of the status byte {6'b0, wel, busy}, which is 0. Each later strobe toggles dout between the low word {2'b0, wel, busy} and the high word. dout_en falls when chip-select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| nib_stb | input | 1 | One-cycle strobe marking a valid input word |
| nib | input | 4 | Input word |
| prot | input | 2^(ADDR_W-16) | Write-protect bit for each 64 KB region |
| busy_len | input | LEN_W | Erase duration in clocks |
| dout | output | 4 | Status word driven during a status read |
| dout_en | output | 1 | Status output enable |
| busy | output | 1 | Erase in progress |
| wel | output | 1 | Write-enable latch |
| er_start | output | 1 | One-cycle erase start to the array stub |
| er_base | output | ADDR_W | First byte address of the erase range |
| er_size | output | ADDR_W+1 | Erase range size in bytes (a power of two) |

## Verification
A miscounted word counter or a wrong opcode compare shows up on the first command. Either a start pulse is missing or extra, or wel has the wrong value, and both are visible one clock after chip-select rises. A wrong region class or address mask shows in er_base or er_size in that same start cycle. A wrong protect index shows as a start for an address that should have been refused. A stale wel or a wrong busy count appears only at the next command, or after busy_len clocks. The status-read path makes both of these readable at any time, so they are exposed without waiting for another erase.

// File: rtl/qfe_pkg.sv
// Shared opcodes and the block-class type for the erase command decoder.
package qfe_pkg;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_BLKER = 8'hD8;
    localparam logic [7:0] OPC_CHPER = 8'hC7;
    localparam logic [7:0] OPC_STAT  = 8'h05;

    typedef enum logic [1:0] {
        BK_8K  = 2'd0,
        BK_32K = 2'd1,
        BK_64K = 2'd2
    } blk_cls_t;
endpackage

// File: rtl/qfe_deser.sv
// Word assembler: counts the strobed words received while chip select is low.
// The first two words form the opcode. Later words shift into the address
// register, so the last ADDR_W bits received are kept.
// Assumes ADDR_W >= 17. The count saturates at 15, which still lets the
// caller spot overlong commands.
module qfe_deser #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              nib_stb,
    input  logic [3:0]        nib,
    output logic [3:0]        cnt,
    output logic [7:0]        opc,
    output logic [ADDR_W-1:0] addr
);
    // Count words and route each one into the opcode or the address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            opc  <= '0;
            addr <= '0;
        end else if (cs_n) begin
            cnt <= '0;
        end else if (nib_stb) begin
            if (cnt < 4'd2) opc <= {opc[3:0], nib};
            else            addr <= {addr[ADDR_W-5:0], nib};
            if (cnt != 4'hF) cnt <= cnt + 4'd1;
        end
    end
endmodule

// File: rtl/qfe_blk_map.sv
// Range decoder, purely combinational. Classifies the address by its 32 KB
// unit, then returns the aligned base, the size in bytes, and whether the
// target is write-protected.
// Assumes one protect bit for each 64 KB region.
module qfe_blk_map
    import qfe_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int NREG   = 1 << (ADDR_W - 16)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              whole,
    input  logic [NREG-1:0]   prot,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W:0]   size,
    output logic              locked
);
    localparam int SEG_W = ADDR_W - 15;
    localparam logic [SEG_W-1:0] SEG_TOP = {SEG_W{1'b1}};

    logic [SEG_W-1:0]  seg;
    blk_cls_t          cls;
    logic [ADDR_W-1:0] mask;

    // Pick the block class from the address, then derive size, base and lock.
    always_comb begin
        seg = addr[ADDR_W-1:15];
        if (seg == '0 || seg == SEG_TOP)
            cls = BK_8K;
        else if (seg == SEG_W'(1) || seg == SEG_TOP - SEG_W'(1))
            cls = BK_32K;
        else
            cls = BK_64K;
        case (cls)
            BK_8K:   size = (ADDR_W+1)'(1) << 13;
            BK_32K:  size = (ADDR_W+1)'(1) << 15;
            default: size = (ADDR_W+1)'(1) << 16;
        endcase
        if (whole) size = (ADDR_W+1)'(1) << ADDR_W;
        mask   = size[ADDR_W-1:0] - ADDR_W'(1);
        base   = whole ? '0 : (addr & ~mask);
        locked = whole ? (|prot) : prot[addr[ADDR_W-1:16]];
    end
endmodule

// File: rtl/qfe_busy_timer.sv
// Self-timed erase duration: busy goes high on start and stays high for len
// clocks. A len of 0 is treated as 1.
// Assumes start is never raised while busy is high; the caller gates it.
module qfe_busy_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             busy
);
    logic [LEN_W-1:0] left;

    // Load the count on start, count down while busy, and release on the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (start) begin
            busy <= 1'b1;
            left <= (len == '0) ? LEN_W'(1) : len;
        end else if (busy) begin
            if (left <= LEN_W'(1)) busy <= 1'b0;
            else                   left <= left - LEN_W'(1);
        end
    end
endmodule

// File: rtl/qflash_erase_dec.sv
// Top level of the erase command decoder. When chip select rises, it checks
// the word count and opcode, then applies the write-enable, protection and
// busy rules. It issues erase starts, runs the busy timer and serves the
// status read.
// Assumes cs_n, nib_stb and nib are already synchronous to clk.
module qflash_erase_dec
    import qfe_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int LEN_W  = 16,
    parameter int NREG   = 1 << (ADDR_W - 16)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              nib_stb,
    input  logic [3:0]        nib,
    input  logic [NREG-1:0]   prot,
    input  logic [LEN_W-1:0]  busy_len,
    output logic [3:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic              wel,
    output logic              er_start,
    output logic [ADDR_W-1:0] er_base,
    output logic [ADDR_W:0]   er_size
);
    logic [3:0]        cnt;
    logic [7:0]        opc;
    logic [ADDR_W-1:0] addr;
    logic              cs_q;
    logic              end_evt, is_wren, is_be, is_ce, go;
    logic [ADDR_W-1:0] m_base;
    logic [ADDR_W:0]   m_size;
    logic              m_locked;
    logic              rd_ph;

    qfe_deser #(.ADDR_W(ADDR_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .nib_stb(nib_stb), .nib(nib),
        .cnt(cnt), .opc(opc), .addr(addr)
    );

    qfe_blk_map #(.ADDR_W(ADDR_W), .NREG(NREG)) u_map (
        .addr(addr), .whole(is_ce), .prot(prot),
        .base(m_base), .size(m_size), .locked(m_locked)
    );

    qfe_busy_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(go), .len(busy_len), .busy(busy)
    );

    // Decode a complete command in the cycle where chip select is first seen high.
    always_comb begin
        end_evt = cs_n & ~cs_q;
        is_wren = (cnt == 4'd2) && (opc == OPC_WREN);
        is_ce   = (cnt == 4'd2) && (opc == OPC_CHPER);
        is_be   = (cnt == 4'd8) && (opc == OPC_BLKER);
        go      = end_evt && !busy && (is_be || is_ce) && wel && !m_locked;
    end

    // Track chip select, the write-enable latch and the erase start outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            wel      <= 1'b0;
            er_start <= 1'b0;
            er_base  <= '0;
            er_size  <= '0;
        end else begin
            cs_q     <= cs_n;
            er_start <= go;
            if (go) begin
                er_base <= m_base;
                er_size <= m_size;
            end
            if (end_evt && !busy) begin
                if (is_wren)              wel <= 1'b1;
                else if (is_be || is_ce)  wel <= 1'b0;
            end
        end
    end

    // Status read: enter after opcode 05h, then toggle the word phase on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_en <= 1'b0;
            rd_ph   <= 1'b0;
        end else if (cs_n) begin
            dout_en <= 1'b0;
            rd_ph   <= 1'b0;
        end else if (nib_stb) begin
            if (cnt == 4'd1 && {opc[3:0], nib} == OPC_STAT) begin
                dout_en <= 1'b1;
                rd_ph   <= 1'b0;
            end else if (dout_en) begin
                rd_ph <= ~rd_ph;
            end
        end
    end

    // Drive the live status word selected by the phase.
    always_comb begin
        dout = rd_ph ? {2'b00, wel, busy} : 4'h0;
    end
endmodule

// File: rtl/qfe_check.sv
// Property checker for qflash_erase_dec. It watches only the ports and is
// attached to every instance by the bind statement below.
module qfe_check #(
    parameter int ADDR_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            er_start,
    input logic            busy,
    input logic            wel,
    input logic            dout_en,
    input logic [3:0]      dout,
    input logic [ADDR_W:0] er_size
);
    assert_start_after_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        er_start |-> $past(cs_n));
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        er_start |=> !er_start);
    assert_size_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        er_start |-> $countones(er_size) == 1);
    assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        er_start |-> !wel);
    assert_busy_with_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> er_start);
    assert_start_sets_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        er_start |-> busy);
    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        er_start |-> !$past(busy));
    assert_status_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> dout[3:2] == 2'b00);
endmodule

bind qflash_erase_dec qfe_check #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .er_start(er_start), .busy(busy),
    .wel(wel), .dout_en(dout_en), .dout(dout), .er_size(er_size)
);

// File: tb/sim_qflash_erase_dec.sv
module sim_qflash_erase_dec;
    localparam int ADDR_W = 21;
    localparam int LEN_W  = 16;
    localparam int NREG   = 1 << (ADDR_W - 16);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic nib_stb = 1'b0;
    logic [3:0] nib = '0;
    logic [NREG-1:0] prot = '0;
    logic [LEN_W-1:0] busy_len = 16'd3;
    logic [3:0] dout;
    logic dout_en, busy, wel, er_start;
    logic [ADDR_W-1:0] er_base;
    logic [ADDR_W:0] er_size;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qflash_erase_dec #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .nib_stb(nib_stb), .nib(nib),
        .prot(prot), .busy_len(busy_len), .dout(dout), .dout_en(dout_en),
        .busy(busy), .wel(wel), .er_start(er_start), .er_base(er_base),
        .er_size(er_size)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint exp_size(input logic [ADDR_W-1:0] a);
        int seg = int'(a >> 15);
        int top = (1 << (ADDR_W - 15)) - 1;
        if (seg == 0 || seg == top) return 64'd8192;
        if (seg == 1 || seg == top - 1) return 64'd32768;
        return 64'd65536;
    endfunction

    function automatic longint exp_base(input logic [ADDR_W-1:0] a);
        return longint'(a) & ~(exp_size(a) - 1);
    endfunction

    task automatic put_nib(input logic [3:0] v);
        @(negedge clk); nib = v; nib_stb = 1'b1;
        @(negedge clk); nib_stb = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        put_nib(b[7:4]);
        put_nib(b[3:0]);
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0;
    endtask

    // Raise chip select and stop at the negedge where er_start is visible.
    task automatic desel();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel(); put_byte(op); desel();
    endtask

    task automatic blk_erase(input logic [ADDR_W-1:0] a);
        logic [23:0] a24 = 24'(a);
        sel(); put_byte(8'hD8); put_byte(a24[23:16]); put_byte(a24[15:8]); put_byte(a24[7:0]);
        desel();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic stat_read(input string req, input logic exp_wel, input logic exp_busy);
        sel(); put_byte(8'h05);
        check({req, " dout_en"}, dout_en, 1);
        check({req, " high word"}, dout, 0);
        put_nib(4'h0);
        check({req, " low word"}, dout, {2'b00, exp_wel, exp_busy});
        put_nib(4'h0);
        check({req, " high again"}, dout, 0);
        @(negedge clk); cs_n = 1'b1; @(negedge clk);
        check({req, " dout_en off"}, dout_en, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0); check("R1 wel", wel, 0);
        check("R1 er_start", er_start, 0); check("R1 dout_en", dout_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 and R12: write enable shown through a status read
        cmd1(8'h06);
        check("R2 wel set", wel, 1);
        stat_read("R12 idle", 1'b1, 1'b0);

        // R3, R4, R10: 8 KB block at the bottom with busy_len=3
        busy_len = 16'd3;
        blk_erase(21'h001234);
        check("R3 start", er_start, 1);
        check("R4 base", er_base, 21'h000000);
        check("R4 size", er_size, 8192);
        check("R8 wel cleared", wel, 0);
        check("R10 busy c1", busy, 1);
        @(negedge clk); @(negedge clk);
        check("R3 one pulse", er_start, 0);
        check("R10 busy c3", busy, 1);
        @(negedge clk);
        check("R10 busy done", busy, 0);

        // R6: no write enable
        blk_erase(21'h0A0000);
        check("R6 no start", er_start, 0);

        // R9: truncated block erase keeps wel
        cmd1(8'h06);
        sel(); put_byte(8'hD8); put_byte(8'h0A); put_byte(8'h00); desel();
        check("R9 short no start", er_start, 0);
        check("R9 short wel kept", wel, 1);
        // R9: overlong chip erase
        sel(); put_byte(8'hC7); put_byte(8'h00); desel();
        check("R9 long no start", er_start, 0);
        check("R9 long wel kept", wel, 1);

        // R7: chip erase refused with one protect bit
        prot = 32'h0000_0100;
        cmd1(8'hC7);
        check("R7 chip locked", er_start, 0);
        check("R7 wel cleared", wel, 0);
        // R7: block in a protected region
        cmd1(8'h06);
        blk_erase(21'h08_4000);
        check("R7 block locked", er_start, 0);
        check("R7 block wel cleared", wel, 0);

        // R5, R10, R11: chip erase with a long busy
        prot = '0;
        busy_len = 16'd60;
        cmd1(8'h06);
        cmd1(8'hC7);
        check("R5 start", er_start, 1);
        check("R5 base", er_base, 0);
        check("R5 size", er_size, 64'd1 << ADDR_W);
        cmd1(8'h06);
        check("R11 wren ignored", wel, 0);
        blk_erase(21'h0A0000);
        check("R11 erase ignored", er_start, 0);
        stat_read("R12 R11 busy", 1'b0, 1'b1);
        wait_idle();
        check("R10 busy released", busy, 0);

        // R10: busy_len of 0 behaves as 1
        busy_len = 16'd0;
        cmd1(8'h06);
        blk_erase(21'h1F_FFFF);
        check("R4 top base", er_base, 21'h1F_E000);
        check("R10 len0 busy", busy, 1);
        @(negedge clk);
        check("R10 len0 done", busy, 0);

        // R3, R4, R6, R7: random addresses, protection and write enable
        busy_len = 16'd2;
        for (int it = 0; it < 60; it++) begin
            logic [ADDR_W-1:0] a;
            bit use_we = ($urandom % 4) != 0;
            bit acc;
            case ($urandom % 4)
                0: a = ADDR_W'($urandom % 32'h10000);
                1: a = ADDR_W'((1 << ADDR_W) - 1 - ($urandom % 32'h10000));
                default: a = ADDR_W'($urandom);
            endcase
            prot = NREG'($urandom & $urandom & $urandom);
            acc = use_we && !prot[a[ADDR_W-1:16]];
            if (use_we) cmd1(8'h06);
            blk_erase(a);
            check("R3 R6 R7 rnd start", er_start, acc);
            if (acc) begin
                check("R4 rnd base", er_base, exp_base(a));
                check("R4 rnd size", er_size, exp_size(a));
            end
            check("R8 rnd wel", wel, 0);
            wait_idle();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule